// File: doc/BRIEF.md
# Lazy Condition Code Evaluator

This block turns the state saved by a deferred-flags scheme into an updated condition-code word. The state is an operation class, an operand size of one, two or four bytes, the source, destination and result words, and the high word of a multiply. A processor core that records this state instead of computing flags on every instruction presents it here only when the flags are needed. One cycle later the block returns the new condition-code word.

New flags are computed only from the sign bits of the operands and the result at the selected size, together with a size-masked zero test. Subtract and compare use an inverted source and an inverted carry. The multiply-step class writes its carry into a separate R bit. Move, logic and shift classes produce only N or Z. The two multiply classes judge the 64-bit product. The new flags are merged into the incoming word under the update mask, and X is always part of that mask. When extended arithmetic is active, Z is protected from being set.

Top module: `lazy_cc_eval`

## Requirements
- R1: While reset is high and after it is released, `outValid` is 0 and `ccsOut` is 0 until the first request is accepted.
- R2: A request presented with `inValid` high at a rising edge produces `outValid` high and its `ccsOut` after that same edge. `outValid` is low after any edge where `inValid` was low.
- R3: The add-like classes are opClass 0 and the unlisted codes 12 to 15. They use the sign bits at operand size (bit 7, 15 or 31 for size 1, 2 or 4). With a negative result, N=1, and V=1 when both operand signs are 0; otherwise C=1 when both are 1. With a non-negative result, Z=1 when the size-masked result is zero, V = both signs 1, and C = either sign 1.
- R4: Subtract (1) and compare (2) apply the R3 rules with the source bitwise inverted, then invert C.
- R5: Multiply-step (3) applies the R3 rules, but its carry goes to R (bit 8) and C stays 0.
- R6: Move (4), and (5), or (6), xor (7) and shift (8) set N from the result sign at operand size. Otherwise they set Z when the size-masked result is zero. V, C and R are 0.
- R7: Signed multiply (9) forms {mulHigh, resVal}. Z=1 if it is zero, else N=1 if bit 63 is set. V=1 when mulHigh is not 32 copies of resVal bit 31. Size is ignored.
- R8: Unsigned multiply (10) sets Z on a zero 64-bit product and N from bit 63. V=1 when mulHigh is non-zero. Size is ignored.
- R9: Flag bits are C=0, V=1, Z=2, N=3, X=4, R=8. The effective mask is `updMask` with bit 4 forced on. Masked bits take the new flag values, so X always becomes 0. Unmasked bits keep `ccsIn`.
- R10: When `extMode` is 1 and the new Z is 1, bit 2 is dropped from the mask, so Z can be cleared but never set.
- R11: The flags-live class (11) returns `ccsIn` unchanged, whatever the mask.
- R12: For the size-dependent classes, any size other than 1, 2 or 4 leaves every new flag 0 before writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe |
| opClass | input | 4 | Operation class code |
| opSize | input | 3 | Operand size in bytes (1, 2, 4) |
| srcVal | input | 32 | Saved source operand |
| dstVal | input | 32 | Saved destination operand |
| resVal | input | 32 | Saved result (low product word for multiplies) |
| mulHigh | input | 32 | High product word |
| ccsIn | input | 32 | Current condition-code word |
| updMask | input | 32 | Per-instruction flag update mask |
| extMode | input | 1 | Extended-arithmetic mode |
| outValid | output | 1 | Result strobe |
| ccsOut | output | 32 | Updated condition-code word |

## Verification
The hardest case to reach is the one where a zero test matters. Extended mode has to meet a zero result at the chosen size while Z is in the mask and Z is clear on input. A 64-bit multiply product also has to be exactly zero, or its high word has to be the exact sign extension of the low word. Uniform random words almost never produce these. The stimulus therefore forces the result, the high word or both to zero, to all ones, or to a sign extension in a fixed share of vectors. It also biases operand sign bits. Directed vectors then cover each class at its boundary.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  localparam int DATA_W = 32;
  localparam int CCS_W  = 32;

  localparam int BIT_C = 0;
  localparam int BIT_V = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;
  localparam int BIT_X = 4;
  localparam int BIT_R = 8;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_CMP   = 4'd2,
    OP_MSTEP = 4'd3,
    OP_MOVE  = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_SHIFT = 4'd8,
    OP_MULS  = 4'd9,
    OP_MULU  = 4'd10,
    OP_LIVE  = 4'd11
  } opClass_e;

  typedef struct packed {
    logic srcInv;
    logic carryInv;
    logic carryToR;
    logic logicRule;
    logic mulSigned;
    logic mulUnsigned;
    logic passThru;
  } lccStrobe_t;
endpackage

// File: rtl/lcc_ctrl.sv
module lcc_ctrl
  import lcc_pkg::*;
(
  input  logic [3:0]  opClass,
  output lccStrobe_t  stb
);
  always_comb begin
    stb = '0;
    case (opClass)
      OP_SUB, OP_CMP: begin
        stb.srcInv   = 1'b1;
        stb.carryInv = 1'b1;
      end
      OP_MSTEP: stb.carryToR = 1'b1;
      OP_MOVE, OP_AND, OP_OR, OP_XOR, OP_SHIFT: stb.logicRule = 1'b1;
      OP_MULS: stb.mulSigned   = 1'b1;
      OP_MULU: stb.mulUnsigned = 1'b1;
      OP_LIVE: stb.passThru    = 1'b1;
      default: stb = '0;
    endcase
  end

  // R11: at most one special evaluation path is chosen per class
  always_comb begin
    p_class_onehot_r11: assert ($onehot0({stb.logicRule, stb.mulSigned,
                                          stb.mulUnsigned, stb.passThru,
                                          stb.carryToR}));
    // R5: the multiply-step path never inverts the carry
    p_mstep_no_inv_r5: assert (!(stb.carryToR && (stb.carryInv || stb.srcInv)));
  end
endmodule

// File: rtl/lcc_datapath.sv
module lcc_datapath
  import lcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  lccStrobe_t        stb,
  input  logic [2:0]        opSize,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] resVal,
  input  logic [DATA_W-1:0] mulHigh,
  input  logic [CCS_W-1:0]  ccsIn,
  input  logic [CCS_W-1:0]  updMask,
  input  logic              extMode,
  output logic              outValid,
  output logic [CCS_W-1:0]  ccsOut
);
  localparam int MSB = DATA_W - 1;
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] srcEff;
  logic              sizeOk, srcSign, dstSign, resSign, resZero;
  logic [PROD_W-1:0] prod;
  logic [CCS_W-1:0]  newFlags, effMask, ccsNext;
  logic              carryRaw;

  assign srcEff = stb.srcInv ? ~srcVal : srcVal;
  assign prod   = {mulHigh, resVal};

  // sign bits and zero test at the operand size
  always_comb begin
    sizeOk  = 1'b1;
    srcSign = 1'b0;
    dstSign = 1'b0;
    resSign = 1'b0;
    resZero = 1'b0;
    case (opSize)
      3'd1: begin
        srcSign = srcEff[7]; dstSign = dstVal[7]; resSign = resVal[7];
        resZero = (resVal[7:0] == 8'd0);
      end
      3'd2: begin
        srcSign = srcEff[15]; dstSign = dstVal[15]; resSign = resVal[15];
        resZero = (resVal[15:0] == 16'd0);
      end
      3'd4: begin
        srcSign = srcEff[MSB]; dstSign = dstVal[MSB]; resSign = resVal[MSB];
        resZero = (resVal == '0);
      end
      default: sizeOk = 1'b0;
    endcase
  end

  // new flag generation
  always_comb begin
    newFlags = '0;
    carryRaw = 1'b0;
    if (stb.mulSigned) begin
      if (prod == '0)        newFlags[BIT_Z] = 1'b1;
      else if (prod[PROD_W-1]) newFlags[BIT_N] = 1'b1;
      newFlags[BIT_V] = (mulHigh != {DATA_W{resVal[MSB]}});
    end else if (stb.mulUnsigned) begin
      newFlags[BIT_Z] = (prod == '0);
      newFlags[BIT_N] = prod[PROD_W-1];
      newFlags[BIT_V] = |mulHigh;
    end else if (sizeOk) begin
      if (stb.logicRule) begin
        if (resSign) newFlags[BIT_N] = 1'b1;
        else         newFlags[BIT_Z] = resZero;
      end else begin
        if (resSign) begin
          newFlags[BIT_N] = 1'b1;
          if (!srcSign && !dstSign)     newFlags[BIT_V] = 1'b1;
          else if (srcSign && dstSign)  carryRaw = 1'b1;
        end else begin
          newFlags[BIT_Z] = resZero;
          newFlags[BIT_V] = srcSign & dstSign;
          carryRaw        = srcSign | dstSign;
        end
        if (stb.carryToR) newFlags[BIT_R] = carryRaw;
        else              newFlags[BIT_C] = carryRaw ^ stb.carryInv;
      end
    end
  end

  // masked writeback
  always_comb begin
    effMask        = updMask;
    effMask[BIT_X] = 1'b1;
    if (extMode && newFlags[BIT_Z]) effMask[BIT_Z] = 1'b0;
    if (stb.passThru) ccsNext = ccsIn;
    else              ccsNext = (ccsIn & ~effMask) | (newFlags & effMask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      ccsOut   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) ccsOut <= ccsNext;
    end
  end

  // R2: one-cycle latency on the result strobe
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R9: X is cleared by every evaluating request
  p_x_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    outValid && !$past(stb.passThru) |-> !ccsOut[BIT_X]);
  // R9: bits outside the mask keep the incoming word
  p_unmasked_kept_r9: assert property (@(posedge clk) disable iff (rst)
    outValid && !$past(stb.passThru) |->
      (((ccsOut ^ $past(ccsIn)) & ~($past(updMask) | (CCS_W'(1) << BIT_X))) == '0));
  // R10: extended mode never sets Z
  p_ext_no_zset_r10: assert property (@(posedge clk) disable iff (rst)
    outValid && $past(extMode) && !$past(stb.passThru) && !$past(ccsIn[BIT_Z])
      |-> !ccsOut[BIT_Z]);
  // R11: flags-live returns the incoming word
  p_live_pass_r11: assert property (@(posedge clk) disable iff (rst)
    outValid && $past(stb.passThru) |-> ccsOut == $past(ccsIn));
endmodule

// File: rtl/lazy_cc_eval.sv
module lazy_cc_eval
  import lcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [3:0]        opClass,
  input  logic [2:0]        opSize,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] resVal,
  input  logic [DATA_W-1:0] mulHigh,
  input  logic [CCS_W-1:0]  ccsIn,
  input  logic [CCS_W-1:0]  updMask,
  input  logic              extMode,
  output logic              outValid,
  output logic [CCS_W-1:0]  ccsOut
);
  lccStrobe_t stb;

  lcc_ctrl u_ctrl (
    .opClass (opClass),
    .stb     (stb)
  );

  lcc_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stb      (stb),
    .opSize   (opSize),
    .srcVal   (srcVal),
    .dstVal   (dstVal),
    .resVal   (resVal),
    .mulHigh  (mulHigh),
    .ccsIn    (ccsIn),
    .updMask  (updMask),
    .extMode  (extMode),
    .outValid (outValid),
    .ccsOut   (ccsOut)
  );
endmodule

// File: tb/lazy_cc_eval_tb.sv
module lazy_cc_eval_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [3:0]  opClass = '0;
  logic [2:0]  opSize = '0;
  logic [31:0] srcVal = '0, dstVal = '0, resVal = '0, mulHigh = '0;
  logic [31:0] ccsIn = '0, updMask = '0;
  logic        extMode = 1'b0;
  logic        outValid;
  logic [31:0] ccsOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lazy_cc_eval u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opClass(opClass), .opSize(opSize),
    .srcVal(srcVal), .dstVal(dstVal), .resVal(resVal), .mulHigh(mulHigh),
    .ccsIn(ccsIn), .updMask(updMask), .extMode(extMode),
    .outValid(outValid), .ccsOut(ccsOut)
  );

  // reference model written from the requirements
  function automatic logic [31:0] refCcs(
      input logic [3:0] op, input logic [2:0] sz,
      input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
      input logic [31:0] hi, input logic [31:0] cin, input logic [31:0] msk,
      input logic ext);
    logic [31:0] f, m;
    logic [63:0] p;
    int sb;
    logic ss, ds, rs, rz, c;
    f = '0;
    p = {hi, r};
    if (op == 4'd11) return cin;                         // R11
    if (op == 4'd9) begin                                // R7
      if (p == 64'd0) f[2] = 1'b1; else if (p[63]) f[3] = 1'b1;
      f[1] = (hi != {32{r[31]}});
    end else if (op == 4'd10) begin                      // R8
      f[2] = (p == 64'd0); f[3] = p[63]; f[1] = (hi != 32'd0);
    end else if (sz == 3'd1 || sz == 3'd2 || sz == 3'd4) begin
      sb = 8 * int'(sz) - 1;
      if (op == 4'd1 || op == 4'd2) s = ~s;              // R4
      ss = s[sb]; ds = d[sb]; rs = r[sb];
      rz = ((r << (31 - sb)) == 32'd0);
      c  = 1'b0;
      if (op >= 4'd4 && op <= 4'd8) begin                // R6
        if (rs) f[3] = 1'b1; else f[2] = rz;
      end else begin                                     // R3
        if (rs) begin
          f[3] = 1'b1;
          if (!ss && !ds) f[1] = 1'b1; else if (ss && ds) c = 1'b1;
        end else begin
          f[2] = rz; f[1] = ss & ds; c = ss | ds;
        end
        if (op == 4'd3) f[8] = c;                        // R5
        else if (op == 4'd1 || op == 4'd2) f[0] = ~c;
        else f[0] = c;
      end
    end                                                  // else R12: zero flags
    m = msk | 32'h10;                                    // R9
    if (ext && f[2]) m[2] = 1'b0;                        // R10
    return (cin & ~m) | (f & m);
  endfunction

  task automatic check(input string req, input logic vExp, input logic [31:0] cExp);
    nChecks++;
    if (outValid !== vExp || ccsOut !== cExp) begin
      nFails++;
      $display("FAIL %s: outValid=%0b ccsOut=%08h expected outValid=%0b ccsOut=%08h",
               req, outValid, ccsOut, vExp, cExp);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic apply(input string req, input logic [3:0] op, input logic [2:0] sz,
      input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
      input logic [31:0] hi, input logic [31:0] cin, input logic [31:0] msk,
      input logic ext);
    logic [31:0] e;
    inValid = 1'b1; opClass = op; opSize = sz; srcVal = s; dstVal = d;
    resVal = r; mulHigh = hi; ccsIn = cin; updMask = msk; extMode = ext;
    e = refCcs(op, sz, s, d, r, hi, cin, msk, ext);
    @(negedge clk);
    check(req, 1'b1, e);
  endtask

  function automatic logic [31:0] pickWord(input int kind);
    case (kind)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0080;
      3: return 32'h0000_8000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 1'b0, 32'h0);

    // R3: positive plus one overflows to negative -> N,V
    apply("R3", 4'd0, 3'd4, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 0, 32'h0, 32'h1FF, 0);
    // R3: byte add of two negatives gives zero byte -> Z,V,C
    apply("R3", 4'd0, 3'd1, 32'h80, 32'h80, 32'h100, 0, 32'h0, 32'h1FF, 0);
    // R4: byte compare equal -> Z, C inverted to 0
    apply("R4", 4'd2, 3'd1, 32'h5, 32'h5, 32'h0, 0, 32'h0, 32'hF, 0);
    // R4: halfword subtract with borrow
    apply("R4", 4'd1, 3'd2, 32'h1, 32'h0, 32'hFFFF, 0, 32'h0, 32'hF, 0);
    // R5: multiply step carries into R, C stays clear
    apply("R5", 4'd3, 3'd4, 32'h8000_0000, 32'h8000_0000, 32'h1, 0, 32'h1, 32'h1FF, 0);
    // R6: halfword move of a value with a zero low half -> Z
    apply("R6", 4'd4, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0001_0000, 0, 32'h3, 32'hF, 0);
    // R6: xor with negative byte -> N only
    apply("R6", 4'd7, 3'd1, 32'h0, 32'h0, 32'h80, 0, 32'h0, 32'hF, 0);
    // R7: signed product equals sign extension -> N, no V
    apply("R7", 4'd9, 3'd7, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'hF, 0);
    // R7: high word not a sign extension -> V
    apply("R7", 4'd9, 3'd1, 0, 0, 32'h1, 32'h2, 32'h0, 32'hF, 0);
    // R8: unsigned with non-zero high word -> V
    apply("R8", 4'd10, 3'd4, 0, 0, 32'h0, 32'h1, 32'h0, 32'hF, 0);
    // R8: 64-bit zero -> Z
    apply("R8", 4'd10, 3'd4, 0, 0, 32'h0, 32'h0, 32'h0, 32'hF, 0);
    // R9: empty mask still clears X and nothing else
    apply("R9", 4'd0, 3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 0, 32'hFFFF_FFFF, 32'h0, 0);
    // R10: extended mode, zero result, Z clear on input -> stays clear
    apply("R10", 4'd4, 3'd4, 0, 0, 32'h0, 0, 32'h0, 32'hF, 1);
    // R10: extended mode, non-zero result clears Z
    apply("R10", 4'd4, 3'd4, 0, 0, 32'h5, 0, 32'h4, 32'hF, 1);
    // R11: flags-live keeps everything, X included
    apply("R11", 4'd11, 3'd4, 32'h8000_0000, 0, 32'h0, 0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 0);
    // R12: unsupported size on compare -> no flags, masked bits cleared
    apply("R12", 4'd2, 3'd3, 32'h0, 32'h8000_0000, 32'h8000_0000, 0, 32'h1FF, 32'hF, 0);
    // R2: idle cycle drops the strobe and holds the word
    begin
      logic [31:0] held;
      held = ccsOut;
      inValid = 1'b0;
      @(negedge clk);
      check("R2", 1'b0, held);
    end

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [3:0]  op;
      logic [2:0]  sz;
      logic [31:0] s, d, r, hi;
      int k;
      op = 4'($urandom % 16);
      k  = int'($urandom % 8);
      sz = (k < 2) ? 3'd1 : (k < 4) ? 3'd2 : (k < 7) ? 3'd4 : 3'($urandom);
      s  = pickWord(int'($urandom % 8));
      d  = pickWord(int'($urandom % 8));
      r  = pickWord(int'($urandom % 6));
      k  = int'($urandom % 4);
      hi = (k == 0) ? 32'd0 : (k == 1) ? {32{r[31]}} : $urandom;
      apply(op == 4'd9 || op == 4'd10 ? "R7/R8 random" :
            op == 4'd11 ? "R11 random" : "R3-R12 random",
            op, sz, s, d, r, hi, $urandom, $urandom, 1'($urandom));
    end
    inValid = 1'b0;
    @(negedge clk);
    check("R2", 1'b0, ccsOut);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule